// File: doc/BRIEF.md
# Delta Sample Fetch Reader

This block fetches the bytes of a one-bit delta-modulated audio sample from memory. It holds the address of the next byte, a count of the bytes still to fetch, and a one-byte holding buffer with a full flag. While the buffer is empty and bytes remain, it raises a memory request that carries the address. It captures the returned byte when the memory side acknowledges. When the last byte of a sample arrives, it either restarts the sample (loop mode) or raises an interrupt, if the interrupt is enabled.

Software programs the block through four byte-wide configuration registers, chosen by a 2-bit select, and through a separate channel-enable strobe. The unit that shifts the buffered byte out to the audio output is modelled only by a take strobe, which empties the buffer. A 7-bit output level register is loaded directly by software. The block drives it to the output, and the block does not change it in any other way.

Top module: `dsf_reader`

## Requirements
- R1: After reset the fetch address is 0xC000, no request is pending, the buffer is empty, the interrupt is low and the output level is 0.
- R2: A configuration write with select 0 (control) takes bit 7 as interrupt enable and bit 6 as loop mode. If bit 7 is written as 0, any pending interrupt is cleared on the next cycle.
- R3: A configuration write with select 1 sets the output level to the written value with bit 7 dropped.
- R4: A configuration write with select 2 stores the start register, and the fetch address becomes 0xC000 + value*64 on the next cycle. Select 3 stores the length register, so a sample holds value*16+1 bytes.
- R5: Any channel-enable write clears the interrupt on the next cycle.
- R6: A channel-enable write with bit 0 gives zero bytes remaining and drops any outstanding request.
- R7: A channel-enable write with bit 1 while no bytes remain restarts the sample: the count is reloaded, the address is set to the start address, and a request is raised only if the buffer is empty. While bytes remain, the write has no effect on the address or request.
- R8: An acknowledge while a request is pending drops the request, fills the buffer with the returned byte, advances the address by one and reduces the remaining count by one.
- R9: Advancing from address 0xFFFF gives 0x8000.
- R10: When the last byte of a sample arrives and loop mode is off, the interrupt is raised if it is enabled, and no further request follows.
- R11: When the last byte arrives in loop mode, the address and count are reloaded, and no request is raised until the buffer is taken.
- R12: Taking a full buffer while bytes remain raises a request on the next cycle.
- R13: An acknowledge with no request pending changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 level, 2 start, 3 length |
| cfg_wdata | input | 8 | Configuration write data |
| ena_we | input | 1 | Channel-enable write strobe |
| ena_bit | input | 1 | Channel-enable value |
| dma_req | output | 1 | Memory fetch request |
| dma_addr | output | 16 | Address of the next byte to fetch |
| dma_ack | input | 1 | Fetched byte is present on dma_rdata |
| dma_rdata | input | 8 | Fetched byte |
| buf_take | input | 1 | Shift unit takes the buffered byte |
| buf_valid | output | 1 | Buffer holds a byte |
| buf_byte | output | 8 | Buffered byte |
| irq | output | 1 | End-of-sample interrupt |
| out_level | output | 7 | Direct-load output level |

## Verification
Every output comes straight from a register, so each strobe, write or acknowledge shows its effect exactly one clock after the edge that samples it. Nothing lags further. The bench holds each stimulus for one rising edge and releases it shortly after that edge. Its reference model then steps once, and it compares every output in that same cycle, before the next stimulus is applied. The loop-end test also checks that no request appears during idle cycles that follow the reload, and that a request appears one cycle after the take.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 12;
    localparam int LVL_W  = 7;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_LEVEL = 2'd1,
        SEL_START = 2'd2,
        SEL_LEN   = 2'd3
    } dsf_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
        logic [DATA_W-1:0] buf_byte;
        logic              buf_full;
        logic              req;
        logic              irq;
        logic              irq_en;
        logic              loop;
        logic [LVL_W-1:0]  level;
        logic [DATA_W-1:0] start_reg;
        logic [DATA_W-1:0] len_reg;
    } dsf_state_t;
endpackage

// File: rtl/dsf_start_addr.sv
module dsf_start_addr #(
    parameter int                        AW    = 16,
    parameter int                        RW    = 8,
    parameter int                        SHIFT = 6,
    parameter logic [AW-1:0]             BASE  = 16'hC000
) (
    input  logic [RW-1:0] reg_val,
    output logic [AW-1:0] start
);
    assign start = BASE + (AW'(reg_val) << SHIFT);
endmodule

// File: rtl/dsf_addr_step.sv
module dsf_addr_step #(
    parameter int            AW   = 16,
    parameter logic [AW-1:0] WRAP = 16'h8000
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    assign nxt = (cur == '1) ? WRAP : cur + AW'(1);
endmodule

// File: rtl/dsf_len_gen.sv
module dsf_len_gen #(
    parameter int CW    = 12,
    parameter int RW    = 8,
    parameter int SHIFT = 4
) (
    input  logic [RW-1:0] reg_val,
    output logic [CW-1:0] len
);
    assign len = (CW'(reg_val) << SHIFT) + CW'(1);
endmodule

// File: rtl/dsf_reader.sv
module dsf_reader
    import dsf_pkg::*;
#(
    parameter logic [ADDR_W-1:0] START_BASE = 16'hC000,
    parameter logic [ADDR_W-1:0] WRAP_BASE  = 16'h8000,
    parameter int                ADDR_SHIFT = 6,
    parameter int                LEN_SHIFT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              ena_we,
    input  logic              ena_bit,
    output logic              dma_req,
    output logic [ADDR_W-1:0] dma_addr,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_rdata,
    input  logic              buf_take,
    output logic              buf_valid,
    output logic [DATA_W-1:0] buf_byte,
    output logic              irq,
    output logic [LVL_W-1:0]  out_level
);
    dsf_state_t s_d, s_q;

    logic [ADDR_W-1:0] start_q_addr, start_wr_addr, addr_nxt;
    logic [CNT_W-1:0]  len_full;

    // start address from the stored register (reloads) and from write data
    dsf_start_addr #(.AW(ADDR_W), .RW(DATA_W), .SHIFT(ADDR_SHIFT), .BASE(START_BASE))
        u_start_q  (.reg_val(s_q.start_reg), .start(start_q_addr));
    dsf_start_addr #(.AW(ADDR_W), .RW(DATA_W), .SHIFT(ADDR_SHIFT), .BASE(START_BASE))
        u_start_wr (.reg_val(cfg_wdata), .start(start_wr_addr));
    dsf_addr_step #(.AW(ADDR_W), .WRAP(WRAP_BASE))
        u_step (.cur(s_q.addr), .nxt(addr_nxt));
    dsf_len_gen #(.CW(CNT_W), .RW(DATA_W), .SHIFT(LEN_SHIFT))
        u_len (.reg_val(s_q.len_reg), .len(len_full));

    // event order inside a cycle: acknowledge, take, register write, enable
    always_comb begin
        s_d = s_q;
        if (dma_ack && s_q.req) begin
            s_d.req      = 1'b0;
            s_d.buf_byte = dma_rdata;
            s_d.buf_full = 1'b1;
            s_d.addr     = addr_nxt;
            if (s_q.remain != '0) s_d.remain = s_q.remain - CNT_W'(1);
            if (s_q.remain <= CNT_W'(1)) begin
                if (s_q.loop) begin
                    s_d.remain = len_full;
                    s_d.addr   = start_q_addr;
                end else if (s_q.irq_en) begin
                    s_d.irq = 1'b1;
                end
            end
        end
        if (buf_take && s_d.buf_full) begin
            s_d.buf_full = 1'b0;
            if (s_d.remain != '0) s_d.req = 1'b1;
        end
        if (cfg_we) begin
            case (dsf_sel_e'(cfg_sel))
                SEL_CTRL: begin
                    s_d.irq_en = cfg_wdata[7];
                    s_d.loop   = cfg_wdata[6];
                    if (!cfg_wdata[7]) s_d.irq = 1'b0;
                end
                SEL_LEVEL: s_d.level = cfg_wdata[LVL_W-1:0];
                SEL_START: begin
                    s_d.start_reg = cfg_wdata;
                    s_d.addr      = start_wr_addr;
                end
                default:   s_d.len_reg = cfg_wdata;
            endcase
        end
        if (ena_we) begin
            s_d.irq = 1'b0;
            if (!ena_bit) begin
                s_d.remain = '0;
                s_d.req    = 1'b0;
            end else if (s_d.remain == '0) begin
                s_d.remain = len_full;
                s_d.addr   = start_q_addr;
                if (!s_d.buf_full) s_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.addr <= START_BASE;
        end else begin
            s_q <= s_d;
        end
    end

    assign dma_req   = s_q.req;
    assign dma_addr  = s_q.addr;
    assign buf_valid = s_q.buf_full;
    assign buf_byte  = s_q.buf_byte;
    assign irq       = s_q.irq;
    assign out_level = s_q.level;

    p_ctrl_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_CTRL && !cfg_wdata[7]) |=> !irq);

    p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_LEVEL) |=> out_level == $past(cfg_wdata[LVL_W-1:0]));

    p_ena_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ena_we |=> !irq);

    p_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_we && !ena_bit) |=> !dma_req);

    p_ack_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && dma_req && !buf_take && !ena_we) |=> (!dma_req && buf_valid));

    p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && dma_req && dma_addr == '1 && s_q.remain > CNT_W'(1) && !ena_we
         && !(cfg_we && cfg_sel == SEL_START)) |=> dma_addr == WRAP_BASE);

    p_nack_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !dma_req && !buf_take && !cfg_we && !ena_we) |=> $stable(s_q));
endmodule

// File: tb/sim_dsf_reader.sv
module sim_dsf_reader;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_we = 0, ena_we = 0, ena_bit = 0, dma_ack = 0, buf_take = 0;
    logic [1:0]  cfg_sel = 0;
    logic [7:0]  cfg_wdata = 0, dma_rdata = 0;
    logic        dma_req, buf_valid, irq;
    logic [15:0] dma_addr;
    logic [7:0]  buf_byte;
    logic [6:0]  out_level;

    dsf_reader u0 (.clk, .rst_n, .cfg_we, .cfg_sel, .cfg_wdata, .ena_we, .ena_bit,
                   .dma_req, .dma_addr, .dma_ack, .dma_rdata, .buf_take, .buf_valid,
                   .buf_byte, .irq, .out_level);

    int n_chk = 0, n_err = 0;

    // reference model state
    logic [15:0] m_addr = 16'hC000;
    logic [11:0] m_rem = 0;
    logic [7:0]  m_buf = 0, m_sreg = 0, m_lreg = 0;
    logic        m_full = 0, m_req = 0, m_irq = 0, m_ien = 0, m_loop = 0;
    logic [6:0]  m_lvl = 0;

    function automatic logic [15:0] f_start(input logic [7:0] r);
        return 16'hC000 + {2'b00, r, 6'b0};
    endfunction
    function automatic logic [11:0] f_len(input logic [7:0] r);
        return {r, 4'b0} + 12'd1;
    endfunction
    function automatic logic [15:0] f_next(input logic [15:0] a);
        return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic tk, input logic ak, input logic [7:0] d,
                         input logic cw, input logic [1:0] sel, input logic [7:0] wd,
                         input logic ew, input logic eb);
        if (ak && m_req) begin
            m_req = 0; m_buf = d; m_full = 1; m_addr = f_next(m_addr);
            if (m_rem != 0) m_rem = m_rem - 1;
            if (m_rem == 0) begin
                if (m_loop) begin m_rem = f_len(m_lreg); m_addr = f_start(m_sreg); end
                else if (m_ien) m_irq = 1;
            end
        end
        if (tk && m_full) begin
            m_full = 0;
            if (m_rem != 0) m_req = 1;
        end
        if (cw) begin
            case (sel)
                2'd0: begin m_ien = wd[7]; m_loop = wd[6]; if (!wd[7]) m_irq = 0; end
                2'd1: m_lvl = wd[6:0];
                2'd2: begin m_sreg = wd; m_addr = f_start(wd); end
                default: m_lreg = wd;
            endcase
        end
        if (ew) begin
            m_irq = 0;
            if (!eb) begin m_rem = 0; m_req = 0; end
            else if (m_rem == 0) begin
                m_rem = f_len(m_lreg); m_addr = f_start(m_sreg);
                if (!m_full) m_req = 1;
            end
        end
    endtask

    task automatic cmp(input string tag);
        chk(tag, "dma_req", dma_req, m_req);
        chk(tag, "dma_addr", dma_addr, m_addr);
        chk(tag, "buf_valid", buf_valid, m_full);
        if (m_full) chk(tag, "buf_byte", buf_byte, m_buf);
        chk(tag, "irq", irq, m_irq);
        chk(tag, "out_level", out_level, m_lvl);
    endtask

    task automatic op(input string tag, input logic tk, input logic ak, input logic [7:0] d,
                      input logic cw, input logic [1:0] sel, input logic [7:0] wd,
                      input logic ew, input logic eb);
        @(negedge clk);
        buf_take = tk; dma_ack = ak; dma_rdata = d;
        cfg_we = cw; cfg_sel = sel; cfg_wdata = wd; ena_we = ew; ena_bit = eb;
        @(posedge clk);
        #2;
        buf_take = 0; dma_ack = 0; cfg_we = 0; ena_we = 0;
        model(tk, ak, d, cw, sel, wd, ew, eb);
        cmp(tag);
    endtask

    task automatic wr(input string tag, input logic [1:0] sel, input logic [7:0] wd);
        op(tag, 0, 0, 8'h00, 1, sel, wd, 0, 0);
    endtask
    task automatic en(input string tag, input logic b);
        op(tag, 0, 0, 8'h00, 0, 2'd0, 8'h00, 1, b);
    endtask
    task automatic ack(input string tag, input logic [7:0] d);
        op(tag, 0, 1, d, 0, 2'd0, 8'h00, 0, 0);
    endtask
    task automatic take(input string tag);
        op(tag, 1, 0, 8'h00, 0, 2'd0, 8'h00, 0, 0);
    endtask
    task automatic idle(input string tag);
        op(tag, 0, 0, 8'h00, 0, 2'd0, 8'h00, 0, 0);
    endtask

    initial begin
        #(8 * 190000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        cmp("R1 reset");
        chk("R1", "reset addr literal", dma_addr, 16'hC000);

        wr("R3 level", 2'd1, 8'hFF);
        chk("R3", "level literal", out_level, 7'h7F);
        wr("R4 start", 2'd2, 8'h10);
        chk("R4", "start literal", dma_addr, 16'hC400);
        wr("R4 length", 2'd3, 8'h00);
        wr("R2 ctrl irq on", 2'd0, 8'h80);
        en("R7 restart", 1);
        chk("R7", "req literal", dma_req, 1'b1);
        ack("R8 ack", 8'hA5);
        chk("R8", "addr literal", dma_addr, 16'hC401);
        chk("R10", "irq literal", irq, 1'b1);
        take("R10 no req after end");
        idle("R10 idle");
        en("R5 enable clears irq", 1);
        ack("R8 refetch", 8'h3C);
        wr("R2 ctrl clears irq", 2'd0, 8'h00);
        chk("R2", "irq literal", irq, 1'b0);
        ack("R13 stray ack", 8'h99);

        // wrap and loop end
        take("R12 empty");
        wr("R4 start FF", 2'd2, 8'hFF);
        wr("R4 length 4", 2'd3, 8'h04);
        wr("R2 loop", 2'd0, 8'h40);
        en("R6 off", 0);
        en("R7 on", 1);
        for (int i = 0; i < 64; i++) begin
            ack("R8 stream", 8'(i));
            en("R7 no restart while bytes remain", 1);
            take("R12 take");
        end
        chk("R9", "wrap literal", dma_addr, 16'h8000);
        ack("R11 last", 8'hEE);
        chk("R11", "reload literal", dma_addr, 16'hFFC0);
        idle("R11 hold");
        idle("R11 hold");
        chk("R11", "no req literal", dma_req, 1'b0);
        take("R11 take raises");
        chk("R12", "req literal", dma_req, 1'b1);
        en("R6 disable", 0);
        ack("R6 ack after disable", 8'h55);
        chk("R6", "buf literal", buf_valid, 1'b0);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            automatic int k = int'($urandom % 100);
            automatic logic [7:0] r = 8'($urandom);
            if (k < 33)      ack("R8 R13 rnd ack", r);
            else if (k < 55) take("R12 rnd take");
            else if (k < 65) wr("R2 rnd ctrl", 2'd0, r);
            else if (k < 70) wr("R3 rnd level", 2'd1, r);
            else if (k < 75) wr("R4 R9 rnd start", 2'd2, (r[0] ? 8'hFF : r));
            else if (k < 80) wr("R4 rnd len", 2'd3, {6'd0, r[1:0]});
            else if (k < 90) en("R7 R10 R11 rnd on", 1);
            else if (k < 93) en("R5 R6 rnd off", 0);
            else             idle("R1 rnd idle");
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule